// File: doc/BRIEF.md
# DMA Channel Address and Transfer Count Unit

This unit serves one channel of a dual-address DMA engine in its sequential and idle modes. It stores three values: a fixed 16-bit peripheral-side address, a 24-bit memory-side pointer and a 16-bit transfer counter. A small control word sets the channel enable, which side the peripheral address feeds, and how the memory pointer moves. For every transfer the unit presents a full 24-bit source and destination address. The peripheral address is widened by filling its top byte with ones. When a transfer completes, the unit steps the memory pointer and counts the counter down. After the last transfer it turns the channel off and raises an end-of-transfer interrupt pulse.

The sequence is run by a three-state machine. `ST_IDLE` waits for the enable bit and moves to `ST_ARMED` when it is set. `ST_ARMED` returns to `ST_IDLE` if the enable bit is cleared. On a request it issues a one-cycle grant (`xfer_go`) and moves to `ST_BUSY`. `ST_BUSY` waits for `xfer_done`. It then returns to `ST_ARMED` if the channel is still enabled, or to `ST_IDLE` if the transfer just finished was the last one. Software writes go through a register select. When a write and a hardware update hit the same register in the same cycle, the write wins. The peripheral address, memory pointer and counter are not cleared by reset.

Top module: `dma_xfer_addr_unit`

## Requirements
- R1: After reset, `chan_en`, `end_irq` and `xfer_go` are 0, and a request does not produce a grant until the enable bit is written to 1.
- R2: The peripheral-side address is presented as {0xFF, io register}. It stays the same after every completed transfer.
- R3: The direction bit is control bit 1. At 0, `src_addr` is the peripheral address and `dst_addr` is the memory pointer. At 1 the two are swapped.
- R4: `xfer_go` is high for exactly one cycle when a request arrives in `ST_ARMED` with the channel enabled. It stays low while in `ST_BUSY` and while the channel is disabled.
- R5: Each accepted `xfer_done` (in `ST_BUSY`) lowers the counter by one.
- R6: The memory pointer moves on each accepted `xfer_done` according to the step field, control bits 3:2. Code 01 adds and code 10 subtracts. Codes 00 and 11 hold the pointer. The step is 1 when the size bit (control bit 4) is 0, and 2 when it is 1. The pointer wraps modulo 2^24.
- R7: When the counter is 1 at an accepted `xfer_done`, the counter becomes 0, `chan_en` clears and `end_irq` is high for one cycle, all on the same clock edge.
- R8: A counter loaded with 0 stands for 65536 transfers. The first completion leaves 0xFFFF and does not end the channel.
- R9: A software write to the counter or the memory pointer in the same cycle as an accepted `xfer_done` sets that register to the written value.
- R10: `xfer_done` outside `ST_BUSY` has no effect on the counter or the memory pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 io addr, 1 counter, 2 memory pointer, 3 control |
| wr_data | input | 24 | Write data; the io address and counter use the low 16 bits |
| rd_sel | input | 2 | Readback select, same coding as `wr_sel` |
| rd_data | output | 24 | Readback value; the io address is read back widened |
| xfer_req | input | 1 | Transfer request |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| xfer_go | output | 1 | Grant that starts a transfer |
| src_addr | output | 24 | Source address of the current transfer |
| dst_addr | output | 24 | Destination address of the current transfer |
| chan_en | output | 1 | Channel enable (control bit 0) |
| end_irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench covers several corner cases:
- **Counter boundaries.** A count of 1, which must end the channel, and a count of 0, which must wrap to 0xFFFF rather than stopping. A design that tested for zero before decrementing would end one transfer early, or never end.
- **Pointer wraparound and step size.** The pointer is checked wrapping in both directions at both step sizes. A design that ignored the size bit, or swapped up and down, would produce a wrong pointer.
- **Same-cycle write against hardware update.** This catches a design that lets the hardware update win over the software write.
- **Stray completions.** `xfer_done` pulses arriving outside a transfer must be ignored. A design that accepted them would move the counter and pointer when it should not.
- **Repeated grants.** Extra grants during `ST_BUSY` or while disabled would start transfers that were never requested.

// File: rtl/dma_au_pkg.sv
package dma_au_pkg;
    localparam int AU_ADDR_W = 24;
    localparam int AU_IO_W   = 16;
    localparam int AU_CNT_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } au_state_e;

    typedef enum logic [1:0] {
        SEL_IO   = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_MEM  = 2'd2,
        SEL_CTRL = 2'd3
    } au_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_HOLD3 = 2'd3
    } au_step_e;

    typedef struct packed {
        logic       wide;
        logic [1:0] step;
        logic       io_is_dst;
        logic       en;
    } au_ctrl_t;

    localparam int AU_CTRL_W = $bits(au_ctrl_t);
endpackage

// File: rtl/dma_au_counter.sv
module dma_au_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign last = (cnt == ONE);

    // Not reset: the count is undefined until software loads it.
    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - ONE;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt == $past(cnt) - ONE)); // R5
endmodule

// File: rtl/dma_au_memptr.sv
module dma_au_memptr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [1:0]        step_mode,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    import dma_au_pkg::*;

    logic [ADDR_W-1:0] mag;
    logic [ADDR_W-1:0] delta;

    assign mag = wide ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        unique case (au_step_e'(step_mode))
            STEP_UP:   delta = mag;
            STEP_DOWN: delta = ~mag + ADDR_W'(1);
            default:   delta = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (load)
            addr <= load_val;
        else if (step_en)
            addr <= addr + delta;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(addr)); // R10
endmodule

// File: rtl/dma_xfer_addr_unit.sv
module dma_xfer_addr_unit #(
    parameter int ADDR_W = dma_au_pkg::AU_ADDR_W,
    parameter int IO_W   = dma_au_pkg::AU_IO_W,
    parameter int CNT_W  = dma_au_pkg::AU_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              xfer_req,
    input  logic              xfer_done,
    output logic              xfer_go,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              chan_en,
    output logic              end_irq
);
    import dma_au_pkg::*;

    localparam int FILL_W = ADDR_W - IO_W;

    au_state_e         state_q, state_d;
    au_ctrl_t          ctrl_q;
    logic [IO_W-1:0]   io_q;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] mem_addr;
    logic [ADDR_W-1:0] io_full;
    logic              cnt_last;
    logic              io_wr, cnt_wr, mem_wr, ctrl_wr;
    logic              done_acc, fin, en_next;

    assign io_wr   = wr_en && (au_sel_e'(wr_sel) == SEL_IO);
    assign cnt_wr  = wr_en && (au_sel_e'(wr_sel) == SEL_CNT);
    assign mem_wr  = wr_en && (au_sel_e'(wr_sel) == SEL_MEM);
    assign ctrl_wr = wr_en && (au_sel_e'(wr_sel) == SEL_CTRL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs of the state machine
    always_comb begin
        xfer_go  = (state_q == ST_ARMED) && ctrl_q.en && xfer_req;
        done_acc = (state_q == ST_BUSY) && xfer_done;
        fin      = done_acc && cnt_last;
        en_next  = ctrl_wr ? wr_data[0] : (fin ? 1'b0 : ctrl_q.en);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ctrl_q.en) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!ctrl_q.en)    state_d = ST_IDLE;
                else if (xfer_req) state_d = ST_BUSY;
            end
            ST_BUSY:  if (xfer_done) state_d = en_next ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            end_irq <= 1'b0;
        end else begin
            end_irq <= fin;
            if (ctrl_wr)
                ctrl_q <= au_ctrl_t'(wr_data[AU_CTRL_W-1:0]);
            else if (fin)
                ctrl_q.en <= 1'b0;
        end
    end

    // Peripheral address: never reset, never stepped.
    always_ff @(posedge clk) begin
        if (io_wr)
            io_q <= wr_data[IO_W-1:0];
    end

    dma_au_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .dec      (done_acc),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    dma_au_memptr #(.ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mem_wr),
        .load_val  (wr_data),
        .step_en   (done_acc),
        .step_mode (ctrl_q.step),
        .wide      (ctrl_q.wide),
        .addr      (mem_addr)
    );

    assign io_full  = {{FILL_W{1'b1}}, io_q};
    assign src_addr = ctrl_q.io_is_dst ? mem_addr : io_full;
    assign dst_addr = ctrl_q.io_is_dst ? io_full  : mem_addr;
    assign chan_en  = ctrl_q.en;

    always_comb begin
        unique case (au_sel_e'(rd_sel))
            SEL_IO:   rd_data = io_full;
            SEL_CNT:  rd_data = {{(ADDR_W-CNT_W){1'b0}}, cnt};
            SEL_MEM:  rd_data = mem_addr;
            default:  rd_data = {{(ADDR_W-AU_CTRL_W){1'b0}}, ctrl_q};
        endcase
    end

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !xfer_go); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq); // R7
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq && !$past(ctrl_wr)) |-> !chan_en); // R7
endmodule

// File: tb/sim_dma_xfer_addr_unit.sv
module sim_dma_xfer_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [23:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [23:0] rd_data;
    logic        xfer_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_go;
    logic [23:0] src_addr, dst_addr;
    logic        chan_en, end_irq;

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    dma_xfer_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_go(xfer_go),
        .src_addr(src_addr), .dst_addr(dst_addr), .chan_en(chan_en),
        .end_irq(end_irq)
    );

    typedef struct packed {
        logic        dir;
        logic [1:0]  mode;
        logic        wide;
        logic [23:0] mem0;
        logic [15:0] io;
        logic [15:0] cnt0;
        logic [23:0] mem1;
        logic [15:0] cnt1;
        logic        fin;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 1'b0, 24'h001000, 16'h1234, 16'h0005, 24'h001001, 16'h0004, 1'b0},
        '{1'b1, 2'd2, 1'b1, 24'h002000, 16'hABCD, 16'h0003, 24'h001FFE, 16'h0002, 1'b0},
        '{1'b0, 2'd0, 1'b1, 24'h003000, 16'h0000, 16'h0001, 24'h003000, 16'h0000, 1'b1},
        '{1'b1, 2'd3, 1'b0, 24'h004000, 16'hFFFF, 16'h0000, 24'h004000, 16'hFFFF, 1'b0},
        '{1'b0, 2'd1, 1'b1, 24'hFFFFFF, 16'h0042, 16'h0002, 24'h000001, 16'h0001, 1'b0},
        '{1'b1, 2'd2, 1'b0, 24'h000000, 16'h8000, 16'h0001, 24'hFFFFFF, 16'h0000, 1'b1}
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic wr(input logic [1:0] sel, input logic [23:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [23:0] val);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    function automatic logic [23:0] ctrl_word(input logic dir, input logic [1:0] mode,
                                              input logic wide, input logic en);
        return {19'd0, wide, mode, dir, en};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [23:0] v;
        logic [23:0] iof;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no grant without enable
        xfer_req = 1'b1;
        #1;
        chk("R1 chan_en", {23'd0, chan_en}, 24'd0);
        chk("R1 end_irq", {23'd0, end_irq}, 24'd0);
        chk("R1 xfer_go", {23'd0, xfer_go}, 24'd0);
        @(negedge clk); @(negedge clk);
        chk("R1 xfer_go after edges", {23'd0, xfer_go}, 24'd0);
        xfer_req = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, 24'd0);
            wr(2'd0, {8'd0, VECS[i].io});
            wr(2'd1, {8'd0, VECS[i].cnt0});
            wr(2'd2, VECS[i].mem0);
            wr(2'd3, ctrl_word(VECS[i].dir, VECS[i].mode, VECS[i].wide, 1'b1));
            @(negedge clk);
            iof = {8'hFF, VECS[i].io};
            chk("R3 src before", src_addr, VECS[i].dir ? VECS[i].mem0 : iof);
            chk("R3 dst before", dst_addr, VECS[i].dir ? iof : VECS[i].mem0);
            xfer_req = 1'b1;
            #1 chk("R4 grant", {23'd0, xfer_go}, 24'd1);
            @(negedge clk);
            chk("R4 no grant in busy", {23'd0, xfer_go}, 24'd0);
            xfer_req = 1'b0;
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            chk("R7 end_irq", {23'd0, end_irq}, {23'd0, VECS[i].fin});
            chk("R7 chan_en", {23'd0, chan_en}, {23'd0, ~VECS[i].fin});
            rd(2'd1, v);
            chk("R5 R8 count", v, {8'd0, VECS[i].cnt1});
            rd(2'd2, v);
            chk("R6 pointer", v, VECS[i].mem1);
            chk("R2 src after", src_addr, VECS[i].dir ? VECS[i].mem1 : iof);
            chk("R2 dst after", dst_addr, VECS[i].dir ? iof : VECS[i].mem1);
            @(negedge clk);
            chk("R7 irq one cycle", {23'd0, end_irq}, 24'd0);
        end

        // R8: zero count runs a second transfer and keeps going
        wr(2'd3, 24'd0);
        wr(2'd1, 24'd0);
        wr(2'd3, ctrl_word(1'b0, 2'd0, 1'b0, 1'b1));
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
            xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        end
        rd(2'd1, v);
        chk("R8 count after two", v, 24'h00FFFE);
        chk("R8 still enabled", {23'd0, chan_en}, 24'd1);

        // R10: done while armed is ignored
        wr(2'd3, 24'd0);
        wr(2'd1, 24'h000005);
        wr(2'd2, 24'h000100);
        wr(2'd3, ctrl_word(1'b0, 2'd1, 1'b0, 1'b1));
        @(negedge clk);
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        rd(2'd1, v);
        chk("R10 count unchanged", v, 24'h000005);
        rd(2'd2, v);
        chk("R10 pointer unchanged", v, 24'h000100);

        // R9: software count write wins over hardware decrement
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        xfer_done = 1'b1;
        wr(2'd1, 24'h000077);
        xfer_done = 1'b0;
        rd(2'd1, v);
        chk("R9 count write wins", v, 24'h000077);
        rd(2'd2, v);
        chk("R9 pointer stepped", v, 24'h000101);

        // R9: software pointer write wins over hardware step
        @(negedge clk);
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        xfer_done = 1'b1;
        wr(2'd2, 24'h00ABCD);
        xfer_done = 1'b0;
        rd(2'd2, v);
        chk("R9 pointer write wins", v, 24'h00ABCD);
        rd(2'd1, v);
        chk("R9 count stepped", v, 24'h000076);

        // R4: no grant once disabled
        wr(2'd3, 24'd0);
        xfer_req = 1'b1;
        @(negedge clk);
        #1 chk("R4 no grant when disabled", {23'd0, xfer_go}, 24'd0);
        xfer_req = 1'b0;

        // R2: io readback widened with ones
        wr(2'd0, 24'h005A5A);
        rd(2'd0, v);
        chk("R2 widened io", v, 24'hFF5A5A);

        finish_run();
    end
endmodule